// File: doc/BRIEF.md
# Buffered burst program sequencer for NOR flash

This block programs a burst of consecutive half-words into a NOR flash device by way of the device's internal write buffer. The host strobes `start` with a half-word start address and a word count. The block then takes the data words from a valid/ready stream and issues every bus write that the buffered-program command needs. Bus writes go out through a single-write master port. Each write is held until the port returns an acknowledge.

The write order is fixed. Two unlock writes come first. Then the block writes the buffer-load command and the count minus one, both to the start address. Each data word follows at an address one half-word above the one before. The confirm command goes last, and it is written to the address of the final data word loaded. `done` pulses once the confirm write is acknowledged. A request with a bad word count is refused without touching the bus. When alignment checking is enabled, a start address that is not aligned to the buffer size is also refused. The block does no completion polling and has no bus timing control.

Top module: `nbp_sequencer`

## Requirements
- R1: After an accepted start, the first two bus writes are data 0x00AA to address 0x555 and then data 0x0055 to address 0x2AA.
- R2: The third bus write is data 0x0025 to the start address.
- R3: The fourth bus write is the word count minus one, zero-extended, to the start address.
- R4: The data words follow in stream order. The first goes to the start address, and each later word goes one address above the previous word.
- R5: The last bus write is data 0x0029 to the address of the last data word, which is the start address plus count minus one. An accepted burst of N words makes exactly N+5 writes.
- R6: A count of zero, or a count above MAX_WORDS, is refused. In that case `err` is high for one cycle in the cycle after the start strobe, no bus write is issued, `busy` stays low and no data word is taken.
- R7: With ALIGN_EN set, a start address whose low log2(MAX_WORDS) bits are not all zero is refused in the same way as R6.
- R8: `in_ready` is low whenever a bus write is pending. Exactly one stream word is taken for each data write.
- R9: Once `bus_req` is high, it stays high with `bus_addr` and `bus_wdata` unchanged until the cycle in which `bus_ack` is high.
- R10: `busy` goes high in the cycle after an accepted start and stays high until the confirm write is acknowledged. `done` is high for one cycle after that, and `busy` is low in that cycle.
- R11: After reset, `busy`, `done`, `err`, `bus_req` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst; sampled only while idle |
| start_addr | input | ADDR_W | Half-word start address |
| word_cnt | input | CNT_W | Number of half-words in the burst |
| in_valid | input | 1 | Stream word present |
| in_data | input | DATA_W | Stream word |
| in_ready | output | 1 | Block takes the stream word this cycle |
| bus_req | output | 1 | Bus write request |
| bus_addr | output | ADDR_W | Bus write half-word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Bus accepts the pending write |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the confirm write is accepted |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
The assertions assume three things about the inputs. `bus_ack` is high only while `bus_req` is high and for no more than one cycle per write. `start` is raised only while `busy` is low. The stream supplies at least as many words as the burst count. The stimulus meets these conditions with a bus responder that acknowledges a pending write after a random wait of zero to two cycles, then drops the acknowledge at once. The stream source offers exactly the count of the current burst, and its valid is gated at random. Each burst is launched only after the previous one has reported `done` or `err`.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL_A,
        ST_UNL_B,
        ST_LOAD,
        ST_COUNT,
        ST_FETCH,
        ST_WDATA,
        ST_CONFIRM
    } nbp_state_e;

    localparam logic [11:0] UNL_OFS_A    = 12'h555;
    localparam logic [11:0] UNL_OFS_B    = 12'h2AA;
    localparam logic [7:0]  CODE_UNL_A   = 8'hAA;
    localparam logic [7:0]  CODE_UNL_B   = 8'h55;
    localparam logic [7:0]  CODE_LOAD    = 8'h25;
    localparam logic [7:0]  CODE_CONFIRM = 8'h29;

    typedef struct packed {
        logic bad_count;
        logic bad_align;
    } nbp_chk_t;

    function automatic logic chk_ok(input nbp_chk_t c);
        return !(c.bad_count || c.bad_align);
    endfunction

    function automatic logic is_write_state(input nbp_state_e s);
        return (s == ST_UNL_A) || (s == ST_UNL_B) || (s == ST_LOAD) ||
               (s == ST_COUNT) || (s == ST_WDATA) || (s == ST_CONFIRM);
    endfunction

endpackage

// File: rtl/nbp_req_check.sv
module nbp_req_check
    import nbp_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 8,
    parameter int MAX_WORDS = 32,
    parameter bit ALIGN_EN  = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    output nbp_chk_t          res
);
    localparam int ALIGN_BITS = $clog2(MAX_WORDS);

    always_comb begin
        res.bad_count = (cnt == '0) || (cnt > CNT_W'(MAX_WORDS));
    end

    generate
        if (ALIGN_EN && ALIGN_BITS > 0) begin : g_align
            always_comb res.bad_align = (addr[ALIGN_BITS-1:0] != '0);
        end else begin : g_noalign
            always_comb res.bad_align = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/nbp_word_track.sv
module nbp_word_track #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  left,
    output logic              is_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            left     <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            left     <= load_cnt;
        end else if (step && !is_last) begin
            cur_addr <= cur_addr + ADDR_W'(1);
            left     <= left - CNT_W'(1);
        end
    end

    assign is_last = (left == CNT_W'(1));

endmodule

// File: rtl/nbp_sequencer.sv
module nbp_sequencer
    import nbp_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int MAX_WORDS = 32,
    parameter bit ALIGN_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    output logic              busy,
    output logic              done,
    output logic              err
);
    nbp_state_e        state_q;
    nbp_chk_t          chk;
    logic [DATA_W-1:0] word_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  left;
    logic              is_last;
    logic              accept;
    logic              step;

    nbp_req_check #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS), .ALIGN_EN(ALIGN_EN)
    ) u_check (
        .addr(start_addr),
        .cnt (word_cnt),
        .res (chk)
    );

    assign accept = (state_q == ST_IDLE) && start && chk_ok(chk);
    assign step   = (state_q == ST_WDATA) && bus_ack;

    nbp_word_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_addr(start_addr),
        .load_cnt (word_cnt),
        .step     (step),
        .cur_addr (cur_addr),
        .left     (left),
        .is_last  (is_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (chk_ok(chk)) state_q <= ST_UNL_A;
                        else             err     <= 1'b1;
                    end
                end
                ST_UNL_A:   if (bus_ack) state_q <= ST_UNL_B;
                ST_UNL_B:   if (bus_ack) state_q <= ST_LOAD;
                ST_LOAD:    if (bus_ack) state_q <= ST_COUNT;
                ST_COUNT:   if (bus_ack) state_q <= ST_FETCH;
                ST_FETCH: begin
                    if (in_valid) begin
                        word_q  <= in_data;
                        state_q <= ST_WDATA;
                    end
                end
                ST_WDATA:   if (bus_ack) state_q <= is_last ? ST_CONFIRM : ST_FETCH;
                ST_CONFIRM: begin
                    if (bus_ack) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_addr  = cur_addr;
        bus_wdata = '0;
        case (state_q)
            ST_UNL_A: begin
                bus_addr  = ADDR_W'(UNL_OFS_A);
                bus_wdata = DATA_W'(CODE_UNL_A);
            end
            ST_UNL_B: begin
                bus_addr  = ADDR_W'(UNL_OFS_B);
                bus_wdata = DATA_W'(CODE_UNL_B);
            end
            ST_LOAD:    bus_wdata = DATA_W'(CODE_LOAD);
            ST_COUNT:   bus_wdata = DATA_W'(left - CNT_W'(1));
            ST_WDATA:   bus_wdata = word_q;
            ST_CONFIRM: bus_wdata = DATA_W'(CODE_CONFIRM);
            default:    bus_wdata = '0;
        endcase
    end

    assign bus_req  = is_write_state(state_q);
    assign in_ready = (state_q == ST_FETCH);
    assign busy     = (state_q != ST_IDLE);

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wdata));

    // R8
    stall_stream_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !in_ready);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !bus_req);

    // R6
    reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy && !bus_req && !in_ready);

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err}));

    // R10
    req_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> busy);

endmodule

// File: tb/nbp_sequencer_tb.sv
module nbp_sequencer_tb_top;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int MAXW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [CW-1:0] st_cnt = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic          busy, done, err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [DW-1:0] dat [64];
    logic [AW-1:0] log_a [2048];
    logic [DW-1:0] log_d [2048];
    int log_n = 0;
    int hs_cnt = 0;
    int hs_base = 0;
    int src_n = 0;
    int stall_bad = 0;
    int hold_bad = 0;
    int wait_cnt = 0;
    logic          pend_q = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic [DW-1:0] pend_d = '0;

    always #2.5 clk = ~clk;

    nbp_sequencer #(
        .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .MAX_WORDS(MAXW), .ALIGN_EN(1'b1)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_addr(st_addr), .word_cnt(st_cnt),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .busy(busy), .done(done), .err(err)
    );

    // Observation at the active edge: log accepted writes, count handshakes, watch holds
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst) begin
            if (bus_req && bus_ack && log_n < 2048) begin
                log_a[log_n] = bus_addr;
                log_d[log_n] = bus_wdata;
                log_n = log_n + 1;
            end
            if (in_valid && in_ready) hs_cnt = hs_cnt + 1;
            if (in_ready && bus_req) stall_bad = stall_bad + 1;
            if (pend_q && !(bus_req && bus_addr == pend_a && bus_wdata == pend_d))
                hold_bad = hold_bad + 1;
            pend_q = bus_req && !bus_ack;
            pend_a = bus_addr;
            pend_d = bus_wdata;
        end
    end

    // Bus responder and stream source, driven away from the active edge
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack  = 1'b0;
            wait_cnt = int'($urandom % 3);
        end else if (bus_req) begin
            if (wait_cnt == 0) bus_ack = 1'b1;
            else wait_cnt = wait_cnt - 1;
        end
        if ((hs_cnt - hs_base) < src_n) begin
            in_valid = ($urandom % 4) != 0;
            in_data  = dat[hs_cnt - hs_base];
        end else begin
            in_valid = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input int i, input logic [AW-1:0] a, input int n);
        if (i == 0) return AW'(12'h555);
        if (i == 1) return AW'(12'h2AA);
        if (i < 4) return a;
        if (i < 4 + n) return a + AW'(i - 4);
        return a + AW'(n - 1);
    endfunction

    function automatic logic [DW-1:0] exp_data(input int i, input int n);
        if (i == 0) return 16'h00AA;
        if (i == 1) return 16'h0055;
        if (i == 2) return 16'h0025;
        if (i == 3) return DW'(n - 1);
        if (i < 4 + n) return dat[i - 4];
        return 16'h0029;
    endfunction

    function automatic string req_of(input int i, input int n);
        if (i < 2) return "R1";
        if (i == 2) return "R2";
        if (i == 3) return "R3";
        if (i < 4 + n) return "R4";
        return "R5";
    endfunction

    task automatic run_burst(input logic [AW-1:0] a, input int n, input bit exp_ok, input string why);
        int lbase;
        int sbase;
        int hbase;
        int busy_gap;
        bit seen;
        for (int k = 0; k < 64; k++) dat[k] = DW'($urandom);
        lbase   = log_n;
        sbase   = stall_bad;
        hbase   = hold_bad;
        hs_base = hs_cnt;
        src_n   = exp_ok ? n : 0;
        @(negedge clk);
        start   = 1'b1;
        st_addr = a;
        st_cnt  = CW'(n);
        @(negedge clk);
        start = 1'b0;
        if (exp_ok) begin
            chk(busy == 1'b1 && err == 1'b0, "R10 busy after start", busy, 1);
            busy_gap = 0;
            seen = 1'b0;
            for (int t = 0; t < 3000 && !seen; t++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
                else if (!busy) busy_gap++;
            end
            chk(seen, "R10 done pulse", seen, 1);
            chk(busy == 1'b0, "R10 busy low with done", busy, 0);
            chk(busy_gap == 0, "R10 busy held", busy_gap, 0);
            @(negedge clk);
            chk(done == 1'b0, "R10 done one cycle", done, 0);
            chk(log_n - lbase == n + 5, "R5 write count", log_n - lbase, n + 5);
            if (log_n - lbase == n + 5) begin
                for (int i = 0; i < n + 5; i++) begin
                    chk(log_a[lbase + i] == exp_addr(i, a, n), req_of(i, n),
                        log_a[lbase + i], exp_addr(i, a, n));
                    chk(log_d[lbase + i] == exp_data(i, n), req_of(i, n),
                        log_d[lbase + i], exp_data(i, n));
                end
            end
            chk(hs_cnt - hs_base == n, "R8 words taken", hs_cnt - hs_base, n);
            chk(stall_bad == sbase, "R8 ready while pending", stall_bad - sbase, 0);
            chk(hold_bad == hbase, "R9 request hold", hold_bad - hbase, 0);
        end else begin
            chk(err == 1'b1 && busy == 1'b0, {why, " err pulse"}, err, 1);
            for (int t = 0; t < 4; t++) begin
                @(negedge clk);
                chk(busy == 1'b0 && err == 1'b0 && in_ready == 1'b0, {why, " stays idle"}, busy, 0);
            end
            chk(log_n == lbase, {why, " no bus writes"}, log_n - lbase, 0);
            chk(hs_cnt == hs_base, {why, " no words taken"}, hs_cnt - hs_base, 0);
        end
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy == 0 && done == 0 && err == 0 && bus_req == 0 && in_ready == 0,
            "R11 reset outputs", {busy, done, err, bus_req, in_ready}, 0);

        run_burst(24'h000040, 1, 1'b1, "R4 single");
        run_burst(24'h0001E0, MAXW, 1'b1, "R5 full");
        run_burst(24'h000100, 0, 1'b0, "R6 zero count");
        run_burst(24'h000100, MAXW + 1, 1'b0, "R6 over max");
        run_burst(24'h000100, 255, 1'b0, "R6 count 255");
        run_burst(24'h000101, 4, 1'b0, "R7 misaligned");
        run_burst(24'h00011F, 1, 1'b0, "R7 misaligned top");
        run_burst(24'hFFFFE0, 2, 1'b1, "R4 top block");

        for (int r = 0; r < 20; r++) begin
            logic [AW-1:0] a;
            int n;
            a = AW'($urandom) & ~AW'(MAXW - 1);
            n = 1 + int'($urandom % MAXW);
            run_burst(a, n, 1'b1, "R4 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule